// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block times the read data path of a single SDRAM device. When the command scheduler grants a Read, it presents the bank and the 8-bit starting column on the request inputs for one cycle. The sequencer then walks the burst. In each cycle of the burst it emits one column address, following the burst length and ordering set in the mode inputs. It also delays a copy of the column-issue strobe by the CAS latency to produce the data-valid strobe. The output enable for the DQ drivers is derived from the same pipeline, so the bus is released to high impedance as soon as the last word has been driven.

The mode inputs (length, ordering, latency) are sampled together with each granted Read and hold for that burst. A full-page burst has no natural end. It steps through every column of the open row, wraps from the top column back to column 0, and keeps running until a stop request or a new Read arrives. A new Read that arrives while a burst is running cuts that burst short. Its first column follows in the very next cycle, so the data stream has no gap.

Top module: `sdram_rd_burst_seq`

## Requirements
- R1: When `rd_go` is high in cycle 0, the next cycle shows `col_vld` high, `col_addr` equal to the `rd_col` of cycle 0 and `col_bank` equal to the `rd_bank` of cycle 0.
- R2: `mode_bl` picks the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4 to 6 give a single beat. For a fixed length, `col_vld` is high for exactly that many consecutive cycles.
- R3: With `mode_ilv` = 0 (sequential) and a length of 2, 4 or 8, beat i keeps the column bits above the block unchanged. The low bits of beat i are (start + i) modulo the length, so the address wraps inside the aligned block.
- R4: With `mode_ilv` = 1 (interleaved) and a length of 2, 4 or 8, the low bits of beat i are the low start bits XOR i. The upper bits stay unchanged.
- R5: A full-page burst issues start + i modulo 256 for beat i, wrapping from column 255 to 0. It ignores `mode_ilv` and runs until `burst_stop` or a new Read.
- R6: If `burst_stop` is high in a cycle with `rd_go` low, no column beat appears in the next cycle. If `rd_go` is high in the same cycle, the new Read wins.
- R7: With `mode_cl` = 3, `dq_vld` is high in cycle 3 + i for beat i, where cycle 0 is the Read cycle. With `mode_cl` = 2 it is high in cycle 2 + i. Codes 0 and 1 act as 2.
- R8: `dq_oe` rises one cycle before the first valid word and stays high through the last valid word. It then falls, so the bus is in high impedance whenever no word is pending.
- R9: A Read that arrives during a running burst truncates it. The new beat 0 appears in the next cycle, and `dq_vld` stays high without a gap across the two bursts.
- R10: While the synchronous active-high `rst` is high at a clock edge, `col_vld`, `dq_vld` and `dq_oe` are low after that edge, even in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_go | input | 1 | Granted Read command, one cycle |
| rd_bank | input | BANK_W | Bank of the Read |
| rd_col | input | COL_W | Starting column of the Read |
| burst_stop | input | 1 | Terminates the running burst |
| mode_bl | input | 3 | Burst length code |
| mode_ilv | input | 1 | 0 sequential, 1 interleaved ordering |
| mode_cl | input | 2 | CAS latency in cycles (2 or 3) |
| col_vld | output | 1 | A column beat is issued this cycle |
| col_bank | output | BANK_W | Bank of the running burst |
| col_addr | output | COL_W | Column address of the current beat |
| dq_vld | output | 1 | Read data word is valid this cycle |
| dq_oe | output | 1 | DQ driver enable (low means high impedance) |

## Verification
The bench builds the block with its defaults: 8 column bits, 2 bank bits and a latency pipeline deep enough for a CAS latency of 3. With 8 column bits, a full-page burst of 260 beats crosses the 255-to-0 wrap in a short run. Latencies 2 and 3 are both in reach, so the one-cycle lead of the output enable and the latency selection are exercised for every burst length and both orderings. Truncation by a new Read, a stop request that coincides with a Read, and a reset in the middle of a burst are checked at cycle level.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

    localparam logic [2:0] BL_ONE  = 3'd0;
    localparam logic [2:0] BL_TWO  = 3'd1;
    localparam logic [2:0] BL_FOUR = 3'd2;
    localparam logic [2:0] BL_EIGHT = 3'd3;
    localparam logic [2:0] BL_PAGE = 3'd7;

    typedef struct packed {
        logic [2:0] bl;
        logic       ilv;
        logic [1:0] cl;
    } rd_mode_t;

    // number of low column bits that wrap inside a burst block
    function automatic int unsigned blk_bits(logic [2:0] bl);
        case (bl)
            BL_TWO:   return 1;
            BL_FOUR:  return 2;
            BL_EIGHT: return 3;
            default:  return 0;
        endcase
    endfunction

    function automatic logic is_page(logic [2:0] bl);
        return bl == BL_PAGE;
    endfunction

    // true when beat index b3 is the final beat of a fixed-length burst
    function automatic logic last_beat(logic [2:0] bl, logic [2:0] b3);
        case (bl)
            BL_TWO:   return b3 == 3'd1;
            BL_FOUR:  return b3 == 3'd3;
            BL_EIGHT: return b3 == 3'd7;
            BL_PAGE:  return 1'b0;
            default:  return 1'b1;
        endcase
    endfunction

    // latency actually used: codes below 2 fall back to 2
    function automatic logic [1:0] cl_eff(logic [1:0] cl);
        return (cl < 2'd2) ? 2'd2 : cl;
    endfunction

endpackage

// File: rtl/rdb_col_gen.sv
module rdb_col_gen #(
    parameter int unsigned COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] beat,
    input  logic [2:0]       bl,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] low;
    int unsigned      nbits;

    always_comb begin
        nbits = rdb_pkg::blk_bits(bl);
        mask  = '0;
        for (int b = 0; b < COL_W; b++) begin
            if (b < int'(nbits)) mask[b] = 1'b1;
        end
        low = ilv ? (start ^ beat) : (start + beat);
        if (rdb_pkg::is_page(bl)) begin
            col = start + beat;
        end else begin
            col = (start & ~mask) | (low & mask);
        end
    end
endmodule

// File: rtl/rdb_lat_pipe.sv
module rdb_lat_pipe #(
    parameter int unsigned CL_MAX = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic [1:0] cl,
    output logic       vld,
    output logic       oe
);
    localparam int unsigned DEPTH = CL_MAX - 1;

    logic [DEPTH-1:0] sh;
    logic [DEPTH:0]   tap;     // tap[d] is the strobe delayed by d cycles
    logic [1:0]       cl_use;
    int unsigned      idx;

    assign tap = {sh, strobe};

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= tap[DEPTH-1:0];
    end

    always_comb begin
        cl_use = rdb_pkg::cl_eff(cl);
        idx    = int'(cl_use) - 2;
        if (idx > DEPTH - 1) idx = DEPTH - 1;
        vld = tap[idx + 1];
        oe  = tap[idx + 1] | tap[idx];
    end
endmodule

// File: rtl/sdram_rd_burst_seq.sv
module sdram_rd_burst_seq #(
    parameter int unsigned COL_W  = 8,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned CL_MAX = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_go,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              burst_stop,
    input  logic [2:0]        mode_bl,
    input  logic              mode_ilv,
    input  logic [1:0]        mode_cl,
    output logic              col_vld,
    output logic [BANK_W-1:0] col_bank,
    output logic [COL_W-1:0]  col_addr,
    output logic              dq_vld,
    output logic              dq_oe
);
    import rdb_pkg::*;

    logic              act_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  start_q;
    logic [COL_W-1:0]  beat_q;
    rd_mode_t          mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            bank_q  <= '0;
            start_q <= '0;
            beat_q  <= '0;
            mode_q  <= '0;
        end else if (rd_go) begin
            act_q   <= 1'b1;
            bank_q  <= rd_bank;
            start_q <= rd_col;
            beat_q  <= '0;
            mode_q  <= '{bl: mode_bl, ilv: mode_ilv, cl: mode_cl};
        end else if (act_q) begin
            if (burst_stop || last_beat(mode_q.bl, beat_q[2:0])) begin
                act_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    rdb_col_gen #(.COL_W(COL_W)) col_gen_i (
        .start (start_q),
        .beat  (beat_q),
        .bl    (mode_q.bl),
        .ilv   (mode_q.ilv),
        .col   (col_addr)
    );

    rdb_lat_pipe #(.CL_MAX(CL_MAX)) lat_pipe_i (
        .clk    (clk),
        .rst    (rst),
        .strobe (act_q),
        .cl     (mode_q.cl),
        .vld    (dq_vld),
        .oe     (dq_oe)
    );

    assign col_vld  = act_q;
    assign col_bank = bank_q;
endmodule

// File: rtl/rdb_seq_chk.sv
module rdb_seq_chk #(
    parameter int unsigned COL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_go,
    input logic [COL_W-1:0] rd_col,
    input logic             burst_stop,
    input logic             col_vld,
    input logic [COL_W-1:0] col_addr,
    input logic             dq_vld,
    input logic             dq_oe,
    input logic [2:0]       lat_bl,
    input logic [1:0]       lat_cl
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)             age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_READ_LOADS: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> (col_vld && col_addr == $past(rd_col)));  // R1

    AST_ONE_BEAT: assert property (@(posedge clk) disable iff (rst)
        (col_vld && !rd_go && (lat_bl == 3'd0 || (lat_bl >= 3'd4 && lat_bl <= 3'd6))) |=> !col_vld);  // R2

    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (col_vld && lat_bl == 3'd7 && !rd_go && !burst_stop && col_addr == {COL_W{1'b1}})
        |=> (col_vld && col_addr == '0));  // R5

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
        (burst_stop && !rd_go) |=> !col_vld);  // R6

    AST_VLD_LAT3: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && dq_vld && lat_cl == 2'd3) |-> $past(col_vld, 2));  // R7

    AST_VLD_LAT2: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && dq_vld && lat_cl != 2'd3) |-> $past(col_vld));  // R7

    AST_OE_COVERS: assert property (@(posedge clk) disable iff (rst)
        dq_vld |-> dq_oe);  // R8
endmodule

bind sdram_rd_burst_seq rdb_seq_chk #(.COL_W(COL_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rd_go      (rd_go),
    .rd_col     (rd_col),
    .burst_stop (burst_stop),
    .col_vld    (col_vld),
    .col_addr   (col_addr),
    .dq_vld     (dq_vld),
    .dq_oe      (dq_oe),
    .lat_bl     (mode_q.bl),
    .lat_cl     (mode_q.cl)
);

// File: tb/sdram_rd_burst_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_rd_burst_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_go = 1'b0;
    logic [1:0] rd_bank = '0;
    logic [7:0] rd_col = '0;
    logic       burst_stop = 1'b0;
    logic [2:0] mode_bl = '0;
    logic       mode_ilv = 1'b0;
    logic [1:0] mode_cl = 2'd2;
    logic       col_vld;
    logic [1:0] col_bank;
    logic [7:0] col_addr;
    logic       dq_vld;
    logic       dq_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sdram_rd_burst_seq dut_i (
        .clk(clk), .rst(rst), .rd_go(rd_go), .rd_bank(rd_bank), .rd_col(rd_col),
        .burst_stop(burst_stop), .mode_bl(mode_bl), .mode_ilv(mode_ilv), .mode_cl(mode_cl),
        .col_vld(col_vld), .col_bank(col_bank), .col_addr(col_addr),
        .dq_vld(dq_vld), .dq_oe(dq_oe)
    );

    // {bl[2:0], ilv, cl[1:0], start[7:0]}
    localparam logic [13:0] VEC [12] = '{
        {3'd0, 1'b0, 2'd2, 8'h13},
        {3'd1, 1'b0, 2'd3, 8'h21},
        {3'd1, 1'b1, 2'd2, 8'h21},
        {3'd2, 1'b0, 2'd2, 8'h45},
        {3'd2, 1'b1, 2'd3, 8'h45},
        {3'd3, 1'b0, 2'd3, 8'h9D},
        {3'd3, 1'b1, 2'd2, 8'h9D},
        {3'd7, 1'b0, 2'd3, 8'hFC},
        {3'd7, 1'b1, 2'd2, 8'h10},
        {3'd5, 1'b0, 2'd3, 8'h77},
        {3'd3, 1'b0, 2'd3, 8'hFE},
        {3'd2, 1'b1, 2'd3, 8'h02}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int blen(input logic [2:0] bl);
        case (bl)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] exp_col(input logic [2:0] bl, input logic ilv,
                                           input logic [7:0] s, input int i);
        int n, off;
        if (bl == 3'd7) return 8'(int'(s) + i);
        n = blen(bl);
        off = ilv ? ((int'(s) % n) ^ i) : (((int'(s) % n) + i) % n);
        return 8'(int'(s) - (int'(s) % n) + off);
    endfunction

    task automatic run_burst(input logic [2:0] bl, input logic ilv, input logic [1:0] cl,
                             input logic [7:0] s);
        int len;
        len = (bl == 3'd7) ? 260 : blen(bl);
        @(negedge clk);
        mode_bl = bl; mode_ilv = ilv; mode_cl = cl;
        rd_go = 1'b1; rd_col = s; rd_bank = s[1:0];
        for (int k = 1; k <= len + int'(cl) + 1; k++) begin
            logic ev, dv, eo;
            @(negedge clk);
            ev = (k <= len);
            dv = (k >= int'(cl)) && (k <= int'(cl) + len - 1);
            eo = (k >= int'(cl) - 1) && (k <= int'(cl) + len - 1);
            if (k == 1) chk(col_bank == s[1:0], "R1 bank", col_bank, s[1:0]);
            chk(col_vld == ev, (bl == 3'd7) ? "R5/R6 col_vld" : "R2 col_vld", col_vld, ev);
            if (ev && col_vld)
                chk(col_addr == exp_col(bl, ilv, s, k - 1),
                    (bl == 3'd7) ? "R5 col_addr" : (ilv ? "R4 col_addr" : "R3 col_addr"),
                    col_addr, exp_col(bl, ilv, s, k - 1));
            chk(dq_vld == dv, "R7 dq_vld", dq_vld, dv);
            chk(dq_oe == eo, "R8 dq_oe", dq_oe, eo);
            rd_go = 1'b0;
            burst_stop = (bl == 3'd7) && (k == len);
        end
        burst_stop = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!col_vld && !dq_vld && !dq_oe, "R10 idle after reset", {col_vld, dq_vld, dq_oe}, 0);

        foreach (VEC[v]) begin
            run_burst(VEC[v][13:11], VEC[v][10], VEC[v][9:8], VEC[v][7:0]);
        end

        // R9 truncation, with a coincident stop that the Read overrides (R6)
        @(negedge clk);
        mode_bl = 3'd3; mode_ilv = 1'b0; mode_cl = 2'd3;
        rd_go = 1'b1; rd_col = 8'h30;
        for (int k = 1; k <= 15; k++) begin
            logic ev, dv, eo;
            int ec;
            @(negedge clk);
            ev = (k <= 11);
            ec = (k <= 3) ? (8'h30 + k - 1) : (8'h50 + k - 4);
            dv = (k >= 3) && (k <= 13);
            eo = (k >= 2) && (k <= 13);
            chk(col_vld == ev, "R9 col_vld", col_vld, ev);
            if (ev && col_vld) chk(col_addr == 8'(ec), "R9 col_addr", col_addr, ec);
            chk(dq_vld == dv, "R9 dq_vld continuous", dq_vld, dv);
            chk(dq_oe == eo, "R8 dq_oe", dq_oe, eo);
            rd_go = (k == 3);
            burst_stop = (k == 3);
            if (k == 3) rd_col = 8'h50;
        end
        rd_go = 1'b0; burst_stop = 1'b0;

        // R10 reset in the middle of a burst
        @(negedge clk);
        mode_bl = 3'd3; mode_cl = 2'd3; rd_go = 1'b1; rd_col = 8'h00;
        @(negedge clk); rd_go = 1'b0;
        @(negedge clk);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk(!col_vld && !dq_vld && !dq_oe, "R10 reset mid-burst", {col_vld, dq_vld, dq_oe}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!col_vld && !dq_vld && !dq_oe, "R10 stays idle", {col_vld, dq_vld, dq_oe}, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule